// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller tracks the power state of a small microcontroller across five operating modes: full-speed run, low-speed run, low-speed sleep, watch and hardware standby. It also has a reset-wait state. When the CPU signals that it has executed a sleep instruction, the controller chooses the next mode. The choice depends on three control bits (standby select, low-speed enable and watchdog clock select) and on the run mode the CPU is in at that moment.

From the current mode the controller drives the CPU clock enable and a vector of peripheral clock enables. In low-speed sleep only a chosen subset of peripherals keeps its clock: the two 8-bit timers and the two watchdogs. In watch mode a smaller subset keeps its clock.

While the CPU is stopped, the controller watches five groups of wake-up sources: external IRQ lines, key-input lines, wake-event lines, peripheral interrupts and NMI. Each source counts only when it passes its own enable and the CPU mask. When a wake-up is accepted, the controller issues a one-cycle exception-start pulse and returns to a run mode. The reset and standby pins are synchronized and take priority over everything else. A reset release counts only after a stabilization time has passed.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: After `rst_n` is released, the controller is in reset-wait. Here `mode_code` is 5, the CPU clock is on, all peripheral clocks are on and `exc_start` is 0. Mode codes: 0 full-speed run, 1 low-speed run, 2 low-speed sleep, 3 watch, 4 hardware standby, 5 reset-wait.
- R2: The reset pin may be released after it has been low for at least STAB_CYCLES cycles. The controller then enters mode 0 and gives exactly one `exc_start` pulse with `exc_reset` high.
- R3: The reset pin may be released before the stabilization count has expired. The controller then stays in reset-wait, gives no pulse and restarts the count from zero on the next low period.
- R4: A sleep request in a run mode picks the next mode as follows.
  - Standby select 1 and watchdog clock select 1 give watch (3).
  - With standby select 0 and watchdog clock select 1:
    - low-speed enable 1 takes mode 0 to mode 1 and mode 1 to mode 2;
    - low-speed enable 0 takes mode 1 to mode 0.
  - Every other combination leaves the mode unchanged.
- R5: In mode 2 the CPU clock is off and `per_clk_en` equals SUBSLEEP_KEEP (default 0x0F: bits 0-1 timers, bits 2-3 watchdogs). In mode 3 it equals WATCH_KEEP (default 0x08). `io_hold` is 1 in modes 2, 3 and 4.
- R6: An IRQ line wakes the controller only when its enable bit is 1 and `cpu_mask` is 0.
- R7: A key-input line or a wake-event line wakes the controller only when its enable bit is 1 and `cpu_mask` is 0.
- R8: A peripheral interrupt wakes the controller only when its interrupt enable is 1 and `cpu_mask` is 0.
- R9: NMI wakes the controller even when `cpu_mask` is 1.
- R10: An accepted wake-up gives one `exc_start` pulse, with `exc_reset` low. From mode 2 the controller goes to mode 1. From mode 3 it goes to mode 1 if low-speed enable is 1, and to mode 0 otherwise.
- R11: The standby pin low forces mode 4 from any mode, with all clocks off. Mode 4 is left only through a valid reset-pin sequence.
- R12: Wake-up requests in run modes, and sleep requests in modes other than 0 and 1, have no effect. They change no mode and give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | Reset pin, active low, asynchronous |
| stby_pin_n | input | 1 | Standby pin, active low, asynchronous |
| sleep_exec | input | 1 | One-cycle strobe: CPU executed a sleep instruction |
| ssby_bit | input | 1 | Standby select control bit |
| lson_bit | input | 1 | Low-speed enable control bit |
| pss_bit | input | 1 | Watchdog clock select control bit |
| irq_req | input | NIRQ | External IRQ requests |
| irq_en | input | NIRQ | Per-line IRQ enables |
| key_req | input | NKEY | Key-input requests |
| key_en | input | NKEY | Key-input enables |
| wev_req | input | NWEV | Wake-event requests |
| wev_en | input | NWEV | Wake-event enables |
| per_irq | input | NPER | Peripheral interrupt requests |
| per_irq_en | input | NPER | Peripheral interrupt enables |
| nmi_req | input | 1 | Non-maskable interrupt request |
| cpu_mask | input | 1 | CPU interrupt mask (blocks all but NMI) |
| mode_code | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | NPER | Peripheral clock enables |
| io_hold | output | 1 | Hold port outputs and retained state |
| exc_start | output | 1 | One-cycle exception-start pulse |
| exc_reset | output | 1 | Qualifies `exc_start` as reset exception |

## Verification
The assertions assume that the mode-control bits and enables are quasi-static register values. They also assume that `sleep_exec` is a single-cycle strobe, and that the request lines and pins stay stable for at least three cycles so that they pass through the two-flop synchronizers. The directed tasks change each control input only on the falling clock edge and hold every request until it has been observed. Before re-entering a sleep mode, they clear all requests and wait for the synchronizers to drain, so no stale request can wake the controller on entry.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    M_ACTIVE   = 3'd0,
    M_SUBACT   = 3'd1,
    M_SUBSLEEP = 3'd2,
    M_WATCH    = 3'd3,
    M_HWSTBY   = 3'd4,
    M_RSTWAIT  = 3'd5
  } lpm_mode_e;

  // Mode chosen by a sleep request issued from a run mode.
  function automatic lpm_mode_e sleep_target(lpm_mode_e cur, logic ssby,
                                             logic lson, logic pss);
    lpm_mode_e nxt;
    nxt = cur;
    if (ssby && pss) begin
      nxt = M_WATCH;
    end else if (!ssby && pss) begin
      if (cur == M_ACTIVE && lson)       nxt = M_SUBACT;
      else if (cur == M_SUBACT && lson)  nxt = M_SUBSLEEP;
      else if (cur == M_SUBACT && !lson) nxt = M_ACTIVE;
    end
    return nxt;
  endfunction

  // Run mode resumed after an accepted wake-up.
  function automatic lpm_mode_e wake_target(lpm_mode_e cur, logic lson);
    if (cur == M_SUBSLEEP) return M_SUBACT;
    return lson ? M_SUBACT : M_ACTIVE;
  endfunction

  function automatic logic is_run(lpm_mode_e m);
    return (m == M_ACTIVE) || (m == M_SUBACT);
  endfunction

  function automatic logic is_held(lpm_mode_e m);
    return (m == M_SUBSLEEP) || (m == M_WATCH) || (m == M_HWSTBY);
  endfunction

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/lpm_stab_cnt.sv
module lpm_stab_cnt #(
  parameter int STAB_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  output logic done
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STAB_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!count_en)      cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int NIRQ = 16,
  parameter int NKEY = 10,
  parameter int NWEV = 8,
  parameter int NPER = 8
) (
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic [NKEY-1:0] key_req,
  input  logic [NKEY-1:0] key_en,
  input  logic [NWEV-1:0] wev_req,
  input  logic [NWEV-1:0] wev_en,
  input  logic [NPER-1:0] per_irq,
  input  logic [NPER-1:0] per_irq_en,
  input  logic            nmi_req,
  input  logic            cpu_mask,
  output logic            wake_ok
);
  logic irq_hit, key_hit, wev_hit, per_hit, maskable_hit;

  assign irq_hit      = |(irq_req & irq_en);
  assign key_hit      = |(key_req & key_en);
  assign wev_hit      = |(wev_req & wev_en);
  assign per_hit      = |(per_irq & per_irq_en);
  assign maskable_hit = irq_hit | key_hit | wev_hit | per_hit;
  assign wake_ok      = nmi_req | (maskable_hit & ~cpu_mask);
endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
  import lpm_pkg::*;
#(
  parameter int              NIRQ          = 16,
  parameter int              NKEY          = 10,
  parameter int              NWEV          = 8,
  parameter int              NPER          = 8,
  parameter int              STAB_CYCLES   = 64,
  parameter logic [NPER-1:0] SUBSLEEP_KEEP = NPER'(8'h0F),
  parameter logic [NPER-1:0] WATCH_KEEP    = NPER'(8'h08)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_pin_n,
  input  logic            stby_pin_n,
  input  logic            sleep_exec,
  input  logic            ssby_bit,
  input  logic            lson_bit,
  input  logic            pss_bit,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic [NKEY-1:0] key_req,
  input  logic [NKEY-1:0] key_en,
  input  logic [NWEV-1:0] wev_req,
  input  logic [NWEV-1:0] wev_en,
  input  logic [NPER-1:0] per_irq,
  input  logic [NPER-1:0] per_irq_en,
  input  logic            nmi_req,
  input  logic            cpu_mask,
  output logic [2:0]      mode_code,
  output logic            cpu_clk_en,
  output logic [NPER-1:0] per_clk_en,
  output logic            io_hold,
  output logic            exc_start,
  output logic            exc_reset
);
  localparam int OFS_KEY = NIRQ;
  localparam int OFS_WEV = OFS_KEY + NKEY;
  localparam int OFS_PER = OFS_WEV + NWEV;
  localparam int OFS_NMI = OFS_PER + NPER;
  localparam int NREQ    = OFS_NMI + 1;

  // Named internal events, observed by the bound checker.
  logic            rst_sync_n;
  logic            stby_sync_n;
  logic            stab_done;
  logic            wake_ok;
  logic [NREQ-1:0] req_raw;
  logic [NREQ-1:0] req_sync;
  logic [1:0]      pin_sync;

  lpm_mode_e mode_q, mode_d;
  logic      exc_start_d, exc_reset_d;

  // Pins: bit 1 standby, bit 0 reset; reset state = reset pin asserted.
  lpm_sync #(.W(2), .RST_VAL(2'b10)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d({stby_pin_n, rst_pin_n}), .q(pin_sync)
  );
  assign rst_sync_n  = pin_sync[0];
  assign stby_sync_n = pin_sync[1];

  assign req_raw = {nmi_req, per_irq, wev_req, key_req, irq_req};

  lpm_sync #(.W(NREQ), .RST_VAL('0)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_raw), .q(req_sync)
  );

  lpm_stab_cnt #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
    .clk(clk), .rst_n(rst_n),
    .count_en(stby_sync_n & ~rst_sync_n),
    .done(stab_done)
  );

  lpm_wake_qual #(.NIRQ(NIRQ), .NKEY(NKEY), .NWEV(NWEV), .NPER(NPER)) u_wake (
    .irq_req   (req_sync[OFS_KEY-1:0]),
    .irq_en    (irq_en),
    .key_req   (req_sync[OFS_WEV-1:OFS_KEY]),
    .key_en    (key_en),
    .wev_req   (req_sync[OFS_PER-1:OFS_WEV]),
    .wev_en    (wev_en),
    .per_irq   (req_sync[OFS_NMI-1:OFS_PER]),
    .per_irq_en(per_irq_en),
    .nmi_req   (req_sync[OFS_NMI]),
    .cpu_mask  (cpu_mask),
    .wake_ok   (wake_ok)
  );

  // Peripheral clock enables per mode.
  function automatic logic [NPER-1:0] per_gate(lpm_mode_e m);
    case (m)
      M_SUBSLEEP: return SUBSLEEP_KEEP;
      M_WATCH:    return WATCH_KEEP;
      M_HWSTBY:   return '0;
      default:    return '1;
    endcase
  endfunction

  always_comb begin
    mode_d      = mode_q;
    exc_start_d = 1'b0;
    exc_reset_d = 1'b0;
    if (!stby_sync_n) begin
      mode_d = M_HWSTBY;
    end else if (!rst_sync_n) begin
      mode_d = M_RSTWAIT;
    end else begin
      case (mode_q)
        M_RSTWAIT: begin
          if (stab_done) begin
            mode_d      = M_ACTIVE;
            exc_start_d = 1'b1;
            exc_reset_d = 1'b1;
          end
        end
        M_HWSTBY: mode_d = M_HWSTBY;
        M_SUBSLEEP, M_WATCH: begin
          if (wake_ok) begin
            mode_d      = wake_target(mode_q, lson_bit);
            exc_start_d = 1'b1;
          end
        end
        default: begin
          if (sleep_exec && is_run(mode_q))
            mode_d = sleep_target(mode_q, ssby_bit, lson_bit, pss_bit);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_RSTWAIT;
      exc_start <= 1'b0;
      exc_reset <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      exc_start <= exc_start_d;
      exc_reset <= exc_reset_d;
    end
  end

  assign mode_code  = mode_q;
  assign cpu_clk_en = is_run(mode_q) || (mode_q == M_RSTWAIT);
  assign per_clk_en = per_gate(mode_q);
  assign io_hold    = is_held(mode_q);
endmodule

// File: rtl/lpm_seq_ctrl_chk.sv
module lpm_seq_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int              NPER          = 8,
  parameter logic [NPER-1:0] SUBSLEEP_KEEP = NPER'(8'h0F),
  parameter logic [NPER-1:0] WATCH_KEEP    = NPER'(8'h08)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      mode_code,
  input logic            cpu_clk_en,
  input logic [NPER-1:0] per_clk_en,
  input logic            exc_start,
  input logic            exc_reset,
  input logic            rst_sync_n,
  input logic            stby_sync_n,
  input logic            stab_done,
  input logic            wake_ok
);
  assert_reset_exc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_start && exc_reset) |-> (mode_code == M_ACTIVE && $past(mode_code) == M_RSTWAIT));

  assert_early_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == M_RSTWAIT && rst_sync_n && !stab_done)
      |=> (mode_code == M_RSTWAIT || mode_code == M_HWSTBY));

  assert_subsleep_clocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == M_SUBSLEEP) |-> (!cpu_clk_en && per_clk_en == SUBSLEEP_KEEP));

  assert_watch_clocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == M_WATCH) |-> (!cpu_clk_en && per_clk_en == WATCH_KEEP));

  assert_exc_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start |=> !exc_start);

  assert_subsleep_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == M_SUBSLEEP && wake_ok && rst_sync_n && stby_sync_n)
      |=> (mode_code == M_SUBACT && exc_start && !exc_reset));

  assert_stby_forces_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_sync_n |=> (mode_code == M_HWSTBY && !cpu_clk_en && per_clk_en == '0));

  assert_no_run_wake_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_start && !exc_reset)
      |-> ($past(mode_code) == M_SUBSLEEP || $past(mode_code) == M_WATCH));
endmodule

bind lpm_seq_ctrl lpm_seq_ctrl_chk #(
  .NPER(NPER), .SUBSLEEP_KEEP(SUBSLEEP_KEEP), .WATCH_KEEP(WATCH_KEEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .cpu_clk_en(cpu_clk_en),
  .per_clk_en(per_clk_en), .exc_start(exc_start), .exc_reset(exc_reset),
  .rst_sync_n(rst_sync_n), .stby_sync_n(stby_sync_n),
  .stab_done(stab_done), .wake_ok(wake_ok)
);

// File: tb/lpm_seq_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_seq_ctrl_tb;
  localparam int STAB = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_pin_n = 1'b0, stby_pin_n = 1'b1, sleep_exec = 1'b0;
  logic        ssby_bit = 1'b0, lson_bit = 1'b0, pss_bit = 1'b0;
  logic [15:0] irq_req = '0, irq_en = '0;
  logic [9:0]  key_req = '0, key_en = '0;
  logic [7:0]  wev_req = '0, wev_en = '0;
  logic [7:0]  per_irq = '0, per_irq_en = '0;
  logic        nmi_req = 1'b0, cpu_mask = 1'b0;
  logic [2:0]  mode_code;
  logic        cpu_clk_en, io_hold, exc_start, exc_reset;
  logic [7:0]  per_clk_en;

  int checks = 0, errors = 0;
  int pulses = 0, rst_pulses = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lpm_seq_ctrl #(.STAB_CYCLES(STAB)) u_dut (
    .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .stby_pin_n(stby_pin_n),
    .sleep_exec(sleep_exec), .ssby_bit(ssby_bit), .lson_bit(lson_bit), .pss_bit(pss_bit),
    .irq_req(irq_req), .irq_en(irq_en), .key_req(key_req), .key_en(key_en),
    .wev_req(wev_req), .wev_en(wev_en), .per_irq(per_irq), .per_irq_en(per_irq_en),
    .nmi_req(nmi_req), .cpu_mask(cpu_mask), .mode_code(mode_code),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .io_hold(io_hold),
    .exc_start(exc_start), .exc_reset(exc_reset)
  );

  always @(negedge clk) if (exc_start) begin
    pulses++;
    if (exc_reset) rst_pulses++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_sleep(input logic s, input logic l, input logic p);
    @(negedge clk);
    ssby_bit = s; lson_bit = l; pss_bit = p; sleep_exec = 1'b1;
    @(negedge clk);
    sleep_exec = 1'b0;
    cycles(1);
  endtask

  task automatic clear_reqs();
    irq_req = '0; key_req = '0; wev_req = '0; per_irq = '0; nmi_req = 1'b0;
    irq_en = '0; key_en = '0; wev_en = '0; per_irq_en = '0; cpu_mask = 1'b0;
    cycles(4);
  endtask

  task automatic expect_wake(input string req, input int exp_mode);
    cycles(6);
    chk({req, " wake pulse count"}, pulses, 1);
    chk({req, " wake not reset kind"}, rst_pulses, 0);
    chk({req, " mode after wake"}, mode_code, exp_mode);
  endtask

  task automatic expect_stay(input string req);
    cycles(6);
    chk({req, " no pulse"}, pulses, 0);
    chk({req, " still asleep"}, mode_code, 2);
  endtask

  task automatic reset_sequence(input int low_cycles);
    @(negedge clk); rst_pin_n = 1'b0;
    cycles(low_cycles);
    pulses = 0; rst_pulses = 0;
    rst_pin_n = 1'b1;
    cycles(6);
  endtask

  task automatic t_power_on();   // R1
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    chk("R1 mode", mode_code, 5);
    chk("R1 cpu clk", cpu_clk_en, 1);
    chk("R1 per clk", per_clk_en, 8'hFF);
    chk("R1 exc", exc_start, 0);
  endtask

  task automatic t_reset_release();   // R2
    cycles(STAB + 10);
    pulses = 0; rst_pulses = 0;
    rst_pin_n = 1'b1;
    cycles(6);
    chk("R2 pulses", pulses, 1);
    chk("R2 reset kind", rst_pulses, 1);
    chk("R2 mode", mode_code, 0);
  endtask

  task automatic t_early_release();   // R3
    reset_sequence(5);
    cycles(10);
    chk("R3 no pulse", pulses, 0);
    chk("R3 held in wait", mode_code, 5);
    reset_sequence(STAB + 8);
    chk("R3 later full release pulse", rst_pulses, 1);
    chk("R3 later full release mode", mode_code, 0);
  endtask

  task automatic t_sleep_table();   // R4
    do_sleep(0, 0, 1); chk("R4 active lson0 stays", mode_code, 0);
    do_sleep(1, 0, 0); chk("R4 active pss0 stays", mode_code, 0);
    do_sleep(0, 1, 1); chk("R4 active to subactive", mode_code, 1);
    do_sleep(0, 1, 0); chk("R4 subactive pss0 stays", mode_code, 1);
    do_sleep(0, 0, 1); chk("R4 subactive to active", mode_code, 0);
  endtask

  task automatic t_subsleep_gating();   // R5, R12
    do_sleep(0, 1, 1);
    do_sleep(0, 1, 1);
    chk("R4 subactive to subsleep", mode_code, 2);
    chk("R5 subsleep cpu clk", cpu_clk_en, 0);
    chk("R5 subsleep per clk", per_clk_en, 8'h0F);
    chk("R5 subsleep io hold", io_hold, 1);
    pulses = 0;
    do_sleep(0, 0, 1);
    chk("R12 sleep in subsleep ignored", mode_code, 2);
    lson_bit = 1'b1;
  endtask

  task automatic t_irq_wake();   // R6, R10
    pulses = 0; rst_pulses = 0;
    irq_req[5] = 1'b1;
    expect_stay("R6 irq disabled");
    irq_en[5] = 1'b1; cpu_mask = 1'b1;
    expect_stay("R6 irq masked");
    cpu_mask = 1'b0;
    expect_wake("R6 R10 irq", 1);
    clear_reqs();
  endtask

  task automatic t_key_wev_wake();   // R7
    do_sleep(0, 1, 1); pulses = 0; rst_pulses = 0;
    key_req[9] = 1'b1;
    expect_stay("R7 key disabled");
    key_en[9] = 1'b1;
    expect_wake("R7 key", 1);
    clear_reqs();
    do_sleep(0, 1, 1); pulses = 0; rst_pulses = 0;
    wev_req[0] = 1'b1; wev_en[0] = 1'b1; cpu_mask = 1'b1;
    expect_stay("R7 wev masked");
    cpu_mask = 1'b0;
    expect_wake("R7 wev", 1);
    clear_reqs();
  endtask

  task automatic t_per_wake();   // R8
    do_sleep(0, 1, 1); pulses = 0; rst_pulses = 0;
    per_irq[7] = 1'b1;
    expect_stay("R8 per disabled");
    per_irq_en[7] = 1'b1;
    expect_wake("R8 per", 1);
    clear_reqs();
  endtask

  task automatic t_nmi_wake();   // R9
    do_sleep(0, 1, 1); pulses = 0; rst_pulses = 0;
    cpu_mask = 1'b1; nmi_req = 1'b1;
    expect_wake("R9 nmi masked cpu", 1);
    clear_reqs();
  endtask

  task automatic t_watch();   // R5, R10
    do_sleep(1, 1, 1);
    chk("R4 subactive to watch", mode_code, 3);
    chk("R5 watch cpu clk", cpu_clk_en, 0);
    chk("R5 watch per clk", per_clk_en, 8'h08);
    chk("R5 watch io hold", io_hold, 1);
    pulses = 0; rst_pulses = 0;
    irq_req[0] = 1'b1; irq_en[0] = 1'b1;
    expect_wake("R10 watch lson1", 1);
    clear_reqs();
    do_sleep(0, 0, 1);
    do_sleep(1, 0, 1);
    chk("R4 active to watch", mode_code, 3);
    pulses = 0; rst_pulses = 0;
    irq_req[0] = 1'b1; irq_en[0] = 1'b1;
    cycles(6);
    chk("R10 watch lson0 pulse", pulses, 1);
    chk("R10 watch lson0 mode", mode_code, 0);
    clear_reqs();
  endtask

  task automatic t_run_ignore();   // R12
    pulses = 0;
    irq_req[3] = 1'b1; irq_en[3] = 1'b1; nmi_req = 1'b1;
    cycles(8);
    chk("R12 run wake no pulse", pulses, 0);
    chk("R12 run wake mode", mode_code, 0);
    clear_reqs();
  endtask

  task automatic t_standby();   // R11
    do_sleep(0, 1, 1);
    do_sleep(0, 1, 1);
    chk("R11 pre subsleep", mode_code, 2);
    stby_pin_n = 1'b0;
    cycles(5);
    chk("R11 standby mode", mode_code, 4);
    chk("R11 standby cpu clk", cpu_clk_en, 0);
    chk("R11 standby per clk", per_clk_en, 0);
    stby_pin_n = 1'b1;
    cycles(5);
    chk("R11 stays standby", mode_code, 4);
    reset_sequence(STAB + 5);
    chk("R11 reset exit pulse", rst_pulses, 1);
    chk("R11 reset exit mode", mode_code, 0);
  endtask

  initial begin
    t_power_on();
    t_reset_release();
    t_early_release();
    t_sleep_table();
    t_subsleep_gating();
    t_irq_wake();
    t_key_wev_wake();
    t_per_wake();
    t_nmi_wake();
    t_watch();
    t_run_ignore();
    t_standby();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule